// File: doc/BRIEF.md
# Multi-Lane Serial Memory Command Sequencer

This block sits on the host side of a serial memory link that can move one, two or four bits per clock. Software or a DMA engine hands it one high-level request at a time: a block read, a block write, a save to nonvolatile cells, or a restore from them. It answers with the whole chain of chip-select-delimited frames that the memory needs for that request. Each frame goes out as a descriptor (opcode, lane count, optional address, optional mode byte, inline register byte, data length and direction) to a lower-level frame shifter, which owns the pins and the bit timing.

The chain it builds covers switching into two-lane or four-lane operation and back again. Four-lane operation also needs a configuration register write before entry and a restore after exit. Writes are wrapped in a write-enable frame and a write-disable frame. Save and restore requests are followed by status reads that repeat until the busy bit clears. A poll budget ends a stuck save or restore with a sticky timeout flag. Even then the lane mode is still restored, so the memory is never left in a multi-lane state.

Top module: `mlane_seq`

## Requirements
- R1: After reset `req_ready` is 1 and `frm_valid`, `seq_done` and `seq_timeout` are 0.
- R2: While `frm_valid` is 1 the frame descriptor holds steady until `frm_done`. `frm_valid` is 0 for at least one cycle after each `frm_done`, so every command has its own frame. `req_ready` is 0 while a sequence runs.
- R3: Lane code 2 (four lanes) first sends opcode 87h on one lane with register byte 42h (length 1), then 38h on one lane. After the body it sends FFh on four lanes, then 87h on one lane with byte 40h.
- R4: Lane code 1 (two lanes) sends 37h on one lane before the body and FFh on two lanes after it, with no configuration register write.
- R5: A write request (op code 1) sends 06h, then 02h with the 24-bit address and `req_len` bytes of write data, then 04h, all on the selected lanes.
- R6: A read request (op code 0) sends 0Bh with the address and a mode byte, then reads `req_len` bytes. The mode byte is A0h when `req_xip` is 1 and 00h when it is 0.
- R7: A save request (op code 2) sends 8Ch and a restore request (op code 3) sends 8Dh. Each is followed by 05h frames that read one byte. These frames repeat while bit 0 of the returned byte is 1; the other bits are ignored.
- R8: If `MAX_POLLS` status reads all return busy, polling stops and `seq_timeout` goes to 1. The exit frames are still sent. `seq_timeout` stays 1 until the next request is accepted, and then it clears.
- R9: `seq_done` is a one-cycle pulse in the cycle after the final frame's `frm_done`, and `req_ready` is 1 in that cycle.
- R10: Lane code 3 is treated as one lane: no mode-switch or configuration frames are sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, request taken this cycle |
| req_op | input | 2 | 0 read, 1 write, 2 save, 3 restore |
| req_lanes | input | 2 | 0 one lane, 1 two lanes, 2 four lanes, 3 one lane |
| req_addr | input | 24 | Memory address |
| req_len | input | LEN_W | Data byte count for read or write |
| req_xip | input | 1 | Chain the next read without an opcode |
| frm_valid | output | 1 | Frame descriptor valid (chip select active) |
| frm_lanes | output | 2 | Lane code of the frame |
| frm_opcode | output | 8 | Command byte |
| frm_addr_en | output | 1 | Frame carries an address |
| frm_addr | output | 24 | Address |
| frm_mode_en | output | 1 | Frame carries a mode byte |
| frm_mode | output | 8 | Mode byte |
| frm_rd | output | 1 | Data phase is a read |
| frm_wbyte | output | 8 | Inline register write byte |
| frm_len | output | LEN_W | Data phase byte count |
| frm_done | input | 1 | Shifter finished the frame |
| frm_rbyte | input | 8 | Last byte read by the frame |
| seq_done | output | 1 | Sequence complete pulse |
| seq_timeout | output | 1 | Poll budget exhausted (sticky) |

## Verification
A wrong step register shows at the frame port within one frame, as a missing, extra or reordered opcode against the expected chain, for example a missing 87h restore or a 04h without 06h. A miscounting poll counter shows as the wrong number of 05h frames and a wrong `seq_timeout` level at `seq_done`. A broken gap or hold shows in the very next cycle as `frm_valid` staying high across a `frm_done`, or as a descriptor that changes mid-frame.

// File: rtl/mlseq_pkg.sv
package mlseq_pkg;

    typedef enum logic [1:0] {OP_READ, OP_WRITE, OP_STORE, OP_RECALL} op_e;
    typedef enum logic [1:0] {LN_SINGLE, LN_DUAL, LN_QUAD, LN_RSVD} lane_e;

    // Order of this enum is the order frames leave the block.
    typedef enum logic [3:0] {
        ST_IDLE, ST_CFGQ, ST_ENTER, ST_WREN, ST_MAIN,
        ST_WRDI, ST_POLL, ST_EXIT, ST_CFGR, ST_FIN
    } step_e;

    localparam logic [7:0] CMD_WRCFG  = 8'h87;
    localparam logic [7:0] CMD_QUADON = 8'h38;
    localparam logic [7:0] CMD_DUALON = 8'h37;
    localparam logic [7:0] CMD_ONELN  = 8'hFF;
    localparam logic [7:0] CMD_WREN   = 8'h06;
    localparam logic [7:0] CMD_WRDI   = 8'h04;
    localparam logic [7:0] CMD_WRITE  = 8'h02;
    localparam logic [7:0] CMD_FREAD  = 8'h0B;
    localparam logic [7:0] CMD_STORE  = 8'h8C;
    localparam logic [7:0] CMD_RECALL = 8'h8D;
    localparam logic [7:0] CMD_RDSR   = 8'h05;
    localparam logic [7:0] CFG_QUAD   = 8'h42;
    localparam logic [7:0] CFG_ONE    = 8'h40;
    localparam logic [7:0] MODE_CHAIN = 8'hA0;
    localparam logic [7:0] MODE_END   = 8'h00;

    typedef struct packed {
        op_e         op;
        lane_e       lanes;
        logic [23:0] addr;
        logic        xip;
    } req_core_t;

    typedef struct packed {
        lane_e       lanes;
        logic [7:0]  opcode;
        logic        addr_en;
        logic [23:0] addr;
        logic        mode_en;
        logic [7:0]  mode;
        logic        rd;
        logic [7:0]  wbyte;
    } frame_t;

    function automatic lane_e eff_lanes(lane_e ln);
        return (ln == LN_RSVD) ? LN_SINGLE : ln;
    endfunction

    function automatic logic step_needed(step_e s, op_e op, lane_e ln);
        logic multi;
        multi = (ln == LN_DUAL) || (ln == LN_QUAD);
        case (s)
            ST_CFGQ, ST_CFGR:  return ln == LN_QUAD;
            ST_ENTER, ST_EXIT: return multi;
            ST_WREN, ST_WRDI:  return op == OP_WRITE;
            ST_POLL:           return (op == OP_STORE) || (op == OP_RECALL);
            ST_MAIN, ST_FIN:   return 1'b1;
            default:           return 1'b0;
        endcase
    endfunction

    // Smallest needed step strictly after s.
    function automatic step_e step_after(step_e s, op_e op, lane_e ln);
        step_e r;
        r = ST_FIN;
        for (int k = int'(ST_FIN); k > int'(s); k--) begin
            if (step_needed(step_e'(4'(k)), op, ln)) r = step_e'(4'(k));
        end
        return r;
    endfunction

endpackage

// File: rtl/mlseq_poll_cnt.sv
module mlseq_poll_cnt #(
    parameter int MAX_POLLS = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic inc,
    output logic last
);
    localparam int CNT_W = $clog2(MAX_POLLS + 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr) cnt <= '0;
        else if (inc)   cnt <= cnt + CNT_W'(1);
    end

    assign last = (cnt == CNT_W'(MAX_POLLS - 1));
endmodule

// File: rtl/mlseq_frame_build.sv
module mlseq_frame_build
    import mlseq_pkg::*;
#(
    parameter int LEN_W = 8
) (
    input  step_e            step,
    input  req_core_t        core,
    input  logic [LEN_W-1:0] len,
    output frame_t           frm,
    output logic [LEN_W-1:0] frm_len
);
    lane_e el;
    assign el = eff_lanes(core.lanes);

    always_comb begin
        frm       = '0;
        frm.lanes = el;
        frm_len   = '0;
        case (step)
            ST_CFGQ, ST_CFGR: begin
                frm.lanes  = LN_SINGLE;
                frm.opcode = CMD_WRCFG;
                frm.wbyte  = (step == ST_CFGQ) ? CFG_QUAD : CFG_ONE;
                frm_len    = LEN_W'(1);
            end
            ST_ENTER: begin
                frm.lanes  = LN_SINGLE;
                frm.opcode = (el == LN_QUAD) ? CMD_QUADON : CMD_DUALON;
            end
            ST_WREN: frm.opcode = CMD_WREN;
            ST_WRDI: frm.opcode = CMD_WRDI;
            ST_EXIT: frm.opcode = CMD_ONELN;
            ST_POLL: begin
                frm.opcode = CMD_RDSR;
                frm.rd     = 1'b1;
                frm_len    = LEN_W'(1);
            end
            ST_MAIN: begin
                case (core.op)
                    OP_READ: begin
                        frm.opcode  = CMD_FREAD;
                        frm.addr_en = 1'b1;
                        frm.addr    = core.addr;
                        frm.mode_en = 1'b1;
                        frm.mode    = core.xip ? MODE_CHAIN : MODE_END;
                        frm.rd      = 1'b1;
                        frm_len     = len;
                    end
                    OP_WRITE: begin
                        frm.opcode  = CMD_WRITE;
                        frm.addr_en = 1'b1;
                        frm.addr    = core.addr;
                        frm_len     = len;
                    end
                    OP_STORE:  frm.opcode = CMD_STORE;
                    default:   frm.opcode = CMD_RECALL;
                endcase
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/mlseq_ctrl.sv
module mlseq_ctrl
    import mlseq_pkg::*;
#(
    parameter int LEN_W     = 8,
    parameter int MAX_POLLS = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  req_core_t        req_core,
    input  logic [LEN_W-1:0] req_len,
    input  logic             frm_done,
    input  logic             stat_busy,
    output logic             req_ready,
    output logic             frm_valid,
    output step_e            step,
    output req_core_t        core,
    output logic [LEN_W-1:0] len,
    output logic             seq_done,
    output logic             seq_timeout
);
    logic  gap;
    logic  accept;
    logic  fdone;
    logic  poll_busy;
    logic  poll_last;
    step_e nxt;

    assign req_ready = (step == ST_IDLE);
    assign frm_valid = (step != ST_IDLE) && !gap;
    assign accept    = req_ready && req_valid;
    assign fdone     = frm_valid && frm_done;
    assign poll_busy = fdone && (step == ST_POLL) && stat_busy;
    assign nxt       = step_after(step, core.op, core.lanes);

    mlseq_poll_cnt #(.MAX_POLLS(MAX_POLLS)) u_poll (
        .clk  (clk),
        .rst  (rst),
        .clr  (accept),
        .inc  (poll_busy),
        .last (poll_last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            step        <= ST_IDLE;
            gap         <= 1'b0;
            seq_done    <= 1'b0;
            seq_timeout <= 1'b0;
            core        <= '0;
            len         <= '0;
        end else begin
            seq_done <= 1'b0;
            gap      <= 1'b0;
            if (accept) begin
                core        <= req_core;
                len         <= req_len;
                seq_timeout <= 1'b0;
                step        <= step_after(ST_IDLE, req_core.op, req_core.lanes);
            end else if (fdone) begin
                gap <= 1'b1;
                if (!(poll_busy && !poll_last)) begin
                    if (poll_busy) seq_timeout <= 1'b1;
                    if (nxt == ST_FIN) begin
                        step     <= ST_IDLE;
                        seq_done <= 1'b1;
                    end else begin
                        step <= nxt;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/mlane_seq.sv
module mlane_seq
    import mlseq_pkg::*;
#(
    parameter int LEN_W     = 8,
    parameter int MAX_POLLS = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [1:0]       req_op,
    input  logic [1:0]       req_lanes,
    input  logic [23:0]      req_addr,
    input  logic [LEN_W-1:0] req_len,
    input  logic             req_xip,
    output logic             frm_valid,
    output logic [1:0]       frm_lanes,
    output logic [7:0]       frm_opcode,
    output logic             frm_addr_en,
    output logic [23:0]      frm_addr,
    output logic             frm_mode_en,
    output logic [7:0]       frm_mode,
    output logic             frm_rd,
    output logic [7:0]       frm_wbyte,
    output logic [LEN_W-1:0] frm_len,
    input  logic             frm_done,
    input  logic [7:0]       frm_rbyte,
    output logic             seq_done,
    output logic             seq_timeout
);
    req_core_t        in_core;
    req_core_t        core;
    step_e            step;
    logic [LEN_W-1:0] len;
    frame_t           frm;
    logic             unused_rbyte_hi;

    assign in_core = '{op: op_e'(req_op), lanes: lane_e'(req_lanes),
                       addr: req_addr, xip: req_xip};
    assign unused_rbyte_hi = ^frm_rbyte[7:1];

    mlseq_ctrl #(.LEN_W(LEN_W), .MAX_POLLS(MAX_POLLS)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .req_core    (in_core),
        .req_len     (req_len),
        .frm_done    (frm_done),
        .stat_busy   (frm_rbyte[0]),
        .req_ready   (req_ready),
        .frm_valid   (frm_valid),
        .step        (step),
        .core        (core),
        .len         (len),
        .seq_done    (seq_done),
        .seq_timeout (seq_timeout)
    );

    mlseq_frame_build #(.LEN_W(LEN_W)) u_build (
        .step    (step),
        .core    (core),
        .len     (len),
        .frm     (frm),
        .frm_len (frm_len)
    );

    assign frm_lanes   = frm.lanes;
    assign frm_opcode  = frm.opcode;
    assign frm_addr_en = frm.addr_en;
    assign frm_addr    = frm.addr;
    assign frm_mode_en = frm.mode_en;
    assign frm_mode    = frm.mode;
    assign frm_rd      = frm.rd;
    assign frm_wbyte   = frm.wbyte;
endmodule

// File: rtl/mlane_seq_chk.sv
module mlane_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       req_ready,
    input logic       frm_valid,
    input logic [1:0] frm_lanes,
    input logic [7:0] frm_opcode,
    input logic       frm_done,
    input logic [7:0] frm_rbyte,
    input logic       seq_done,
    input logic       seq_timeout
);
    assert_hold_desc_R2: assert property (@(posedge clk) disable iff (rst)
        frm_valid && !frm_done |=> frm_valid && $stable(frm_opcode) && $stable(frm_lanes));

    assert_frame_gap_R2: assert property (@(posedge clk) disable iff (rst)
        frm_valid && frm_done |=> !frm_valid);

    assert_busy_excl_R2: assert property (@(posedge clk) disable iff (rst)
        !(req_ready && frm_valid));

    assert_quad_on_single_R3: assert property (@(posedge clk) disable iff (rst)
        frm_valid && frm_opcode == 8'h38 |-> frm_lanes == 2'd0);

    assert_poll_stop_R7: assert property (@(posedge clk) disable iff (rst)
        frm_valid && frm_done && frm_opcode == 8'h05 && !frm_rbyte[0]
        |=> ##1 !(frm_valid && frm_opcode == 8'h05));

    assert_timeout_src_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(seq_timeout) |-> $past(frm_done) && $past(frm_opcode) == 8'h05);

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        seq_done |=> !seq_done);

    assert_done_ready_R9: assert property (@(posedge clk) disable iff (rst)
        seq_done |-> req_ready);
endmodule

bind mlane_seq mlane_seq_chk u_chk (.*);

// File: tb/mlane_seq_test.sv
module mlane_seq_test;
    localparam int LEN_W    = 8;
    localparam int TB_POLLS = 4;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             req_valid = 1'b0;
    logic             req_ready;
    logic [1:0]       req_op = '0;
    logic [1:0]       req_lanes = '0;
    logic [23:0]      req_addr = '0;
    logic [LEN_W-1:0] req_len = '0;
    logic             req_xip = 1'b0;
    logic             frm_valid;
    logic [1:0]       frm_lanes;
    logic [7:0]       frm_opcode;
    logic             frm_addr_en;
    logic [23:0]      frm_addr;
    logic             frm_mode_en;
    logic [7:0]       frm_mode;
    logic             frm_rd;
    logic [7:0]       frm_wbyte;
    logic [LEN_W-1:0] frm_len;
    logic             frm_done = 1'b0;
    logic [7:0]       frm_rbyte = '0;
    logic             seq_done;
    logic             seq_timeout;

    int checks = 0;
    int fails  = 0;
    int busy_left = 0;
    logic [63:0] exp_q[$];
    string       tag_q[$];

    always #4 clk = ~clk;

    mlane_seq #(.LEN_W(LEN_W), .MAX_POLLS(TB_POLLS)) uut (.*);

    function automatic logic [63:0] pack(logic [1:0] ln, logic [7:0] op, logic aen,
        logic [23:0] ad, logic men, logic [7:0] md, logic rd, logic [7:0] wb,
        logic [7:0] ln_b);
        return {3'b0, ln, op, aen, ad, men, md, rd, wb, ln_b};
    endfunction

    task automatic check(input logic ok, input string what, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic push(input logic [1:0] ln, input logic [7:0] op, input logic aen,
        input logic [23:0] ad, input logic men, input logic [7:0] md, input logic rd,
        input logic [7:0] wb, input logic [7:0] lb, input string tag);
        exp_q.push_back(pack(ln, op, aen, ad, men, md, rd, wb, lb));
        tag_q.push_back(tag);
    endtask

    // Behavioural frame shifter and scoreboard monitor.
    initial begin
        logic       act;
        int         cnt;
        logic [7:0] cur_op;
        logic [63:0] got;
        logic [63:0] want;
        string      tg;
        act = 1'b0;
        cnt = 0;
        cur_op = '0;
        forever begin
            @(negedge clk);
            if (!act) begin
                if (frm_valid) begin
                    act = 1'b1;
                    cnt = 2;
                    cur_op = frm_opcode;
                    got = pack(frm_lanes, frm_opcode, frm_addr_en, frm_addr, frm_mode_en,
                               frm_mode, frm_rd, frm_wbyte, frm_len);
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R2 unexpected frame", got, '0);
                    end else begin
                        want = exp_q.pop_front();
                        tg = tag_q.pop_front();
                        check(got == want, tg, got, want);
                    end
                end
            end else if (frm_done) begin
                frm_done = 1'b0;
                act = 1'b0;
                check(!frm_valid, "R2 chip select gap after frame", 64'(frm_valid), 64'd0);
            end else if (cnt == 0) begin
                if (cur_op == 8'h05) begin
                    if (busy_left > 0) begin
                        frm_rbyte = 8'h03;
                        busy_left--;
                    end else begin
                        frm_rbyte = 8'h02;
                    end
                end else begin
                    frm_rbyte = 8'h01;
                end
                frm_done = 1'b1;
            end else begin
                cnt--;
            end
        end
    end

    task automatic run_seq(input logic [1:0] op, input logic [1:0] ln, input logic [23:0] ad,
        input logic [7:0] len, input logic xip, input int busy_n, input logic exp_tmo,
        input string tag);
        logic [1:0] el;
        logic       quad;
        logic       multi;
        int         npoll;
        logic       seen;
        el    = (ln == 2'd3) ? 2'd0 : ln;
        quad  = (ln == 2'd2);
        multi = (ln == 2'd1) || (ln == 2'd2);
        if (quad)  push(0, 8'h87, 0, 0, 0, 0, 0, 8'h42, 1, {tag, " R3 cfg to quad"});
        if (multi) push(0, quad ? 8'h38 : 8'h37, 0, 0, 0, 0, 0, 0, 0,
                        quad ? {tag, " R3 quad entry"} : {tag, " R4 dual entry"});
        case (op)
            2'd0: push(el, 8'h0B, 1, ad, 1, xip ? 8'hA0 : 8'h00, 1, 0, len, {tag, " R6 read"});
            2'd1: begin
                push(el, 8'h06, 0, 0, 0, 0, 0, 0, 0, {tag, " R5 wren"});
                push(el, 8'h02, 1, ad, 0, 0, 0, 0, len, {tag, " R5 write"});
                push(el, 8'h04, 0, 0, 0, 0, 0, 0, 0, {tag, " R5 wrdi"});
            end
            default: begin
                push(el, (op == 2'd2) ? 8'h8C : 8'h8D, 0, 0, 0, 0, 0, 0, 0, {tag, " R7 nv op"});
                npoll = exp_tmo ? TB_POLLS : busy_n + 1;
                for (int i = 0; i < npoll; i++)
                    push(el, 8'h05, 0, 0, 0, 0, 1, 0, 1, {tag, " R7 R8 status poll"});
            end
        endcase
        if (multi) push(el, 8'hFF, 0, 0, 0, 0, 0, 0, 0,
                        quad ? {tag, " R3 quad exit"} : {tag, " R4 dual exit"});
        if (quad)  push(0, 8'h87, 0, 0, 0, 0, 0, 8'h40, 1, {tag, " R3 cfg restore"});
        busy_left = busy_n;

        @(negedge clk);
        check(req_ready, {tag, " R9 ready before request"}, 64'(req_ready), 64'd1);
        req_op = op; req_lanes = ln; req_addr = ad; req_len = len; req_xip = xip;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check(!req_ready, {tag, " R2 ready low while busy"}, 64'(req_ready), 64'd0);
        check(!seq_timeout, {tag, " R8 timeout cleared on accept"}, 64'(seq_timeout), 64'd0);
        seen = 1'b0;
        for (int i = 0; i < 3000 && !seen; i++) begin
            if (seq_done) seen = 1'b1;
            else @(negedge clk);
        end
        check(seen, {tag, " R9 done pulse"}, 64'(seen), 64'd1);
        check(seq_timeout == exp_tmo, {tag, " R8 timeout flag"}, 64'(seq_timeout), 64'(exp_tmo));
        check(exp_q.size() == 0, {tag, " R2 all frames issued"}, 64'(exp_q.size()), 64'd0);
        @(negedge clk);
        check(!seq_done, {tag, " R9 done one cycle"}, 64'(seq_done), 64'd0);
        check(seq_timeout == exp_tmo, {tag, " R8 timeout sticky"}, 64'(seq_timeout), 64'(exp_tmo));
        exp_q.delete();
        tag_q.delete();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(req_ready && !frm_valid && !seq_done && !seq_timeout, "R1 reset state",
              {60'd0, req_ready, frm_valid, seq_done, seq_timeout}, 64'h8);

        run_seq(2'd0, 2'd0, 24'h123456, 8'd4,  1'b1, 0, 1'b0, "rd1 xip");
        run_seq(2'd0, 2'd2, 24'hABCDEF, 8'd16, 1'b0, 0, 1'b0, "rd4");
        run_seq(2'd1, 2'd0, 24'h000010, 8'd3,  1'b0, 0, 1'b0, "wr1");
        run_seq(2'd1, 2'd1, 24'hFFFFFE, 8'd2,  1'b0, 0, 1'b0, "wr2");
        run_seq(2'd2, 2'd0, 24'h0,      8'd0,  1'b0, 2, 1'b0, "store1");
        run_seq(2'd3, 2'd2, 24'h0,      8'd0,  1'b0, 0, 1'b0, "recall4");
        run_seq(2'd2, 2'd1, 24'h0,      8'd0,  1'b0, TB_POLLS, 1'b1, "store2 tmo");
        run_seq(2'd0, 2'd3, 24'h00F00F, 8'd1,  1'b1, 0, 1'b0, "rd R10 lanes3");
        run_seq(2'd3, 2'd0, 24'h0,      8'd0,  1'b0, TB_POLLS - 1, 1'b0, "recall edge");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule